// File: doc/BRIEF.md
# DDR Command Bus Legality Monitor

This block sits beside the command bus of a four-bank double-data-rate SDRAM and checks each command, one per clock, against the state of the banks. It tracks which banks hold an open row, whether a write burst with auto-precharge is still running, and whether the bus is inside the recovery window that follows a mode-register write. When a command arrives in a state that does not allow it, the block raises a one-cycle flag with a 3-bit reason code. It then updates its own bank state as if the command had been accepted, so checking carries on through a faulty stream.

The monitor only observes. It drives nothing towards the memory and ignores the data lanes. It is meant for a simulation environment or for an on-chip trace point, wired in parallel to the pins of a memory controller.

Top module: `ddr_cmd_checker`

## Requirements
- R1: A cycle decodes to a command only when CKE was high on the previous clock. CS# high, or {RAS#,CAS#,WE#} = 111, is a no-operation. With CKE low on the current clock, every encoding except refresh (001) is a no-operation, and refresh becomes self-refresh entry. A no-operation never raises a violation.
- R2: BA[1:0] picks one of four banks: 00, 01, 10 and 11 are separate banks for activate (011), read (101), write (100) and precharge (010).
- R3: A precharge with A10/AP high closes all four banks whatever BA holds. With A10/AP low it closes only the bank that BA selects.
- R4: A mode-register write (000), standard or extended, while any bank is open gives code 2.
- R5: In the 2 clocks after a mode-register write, any command other than a no-operation gives code 1. This check takes precedence over all other checks.
- R6: Auto refresh, or self-refresh entry, while any bank is open gives code 3.
- R7: A read or write to an idle bank gives code 5.
- R8: An activate to a bank that is already open gives code 4.
- R9: A write with A10/AP high starts a lockout of BURST_LEN/2 clocks after the command. Any read or write during the lockout gives code 6, and this takes precedence over code 5. At the end of the lockout the written bank is idle.
- R10: A read with A10/AP high closes the bank it targets. A read or write with A10/AP low leaves the bank open.
- R11: Burst stop (110) never raises a violation outside the recovery window of R5.
- R12: The flag and the code appear on the clock edge after the command. The flag lasts one cycle, and the code is 0 when the flag is low. Both are low after reset. Bank state is updated as if the command had been accepted, even when it raised a violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory command clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Clock enable as seen on the bus |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank address |
| addr_ap | input | 1 | Address bit A10: auto-precharge on read/write, all-banks on precharge |
| viol | output | 1 | One-cycle violation pulse |
| viol_code | output | 3 | Reason: 0 none, 1 recovery window, 2 mode write with open bank, 3 refresh with open bank, 4 double activate, 5 access to idle bank, 6 access during write auto-precharge |

## Verification
A bank flag held in the wrong value stays silent until a later command touches that bank. That command then shows a missing or spurious code 4 or 5, or a wrong code 2 or 3 for all-bank commands, one clock after it is issued. An off-by-one in the lockout or recovery counters shows up as a code 6 or 1 that appears or goes missing on a command placed exactly at the window edge. The stimulus therefore puts commands directly at these edges, and mixes in long random streams that revisit banks after many opens and closes.

// File: rtl/ddr_chk_pkg.sv
// Shared types for the DDR command legality monitor.
// Assumes: one command per clock, four-bit strobe group decoded externally to op_e.
package ddr_chk_pkg;

    // Decoded bus operation.
    typedef enum logic [2:0] {
        OP_NOP = 3'd0,
        OP_ACT = 3'd1,
        OP_RD  = 3'd2,
        OP_WR  = 3'd3,
        OP_PRE = 3'd4,
        OP_REF = 3'd5,
        OP_MRS = 3'd6,
        OP_BST = 3'd7
    } op_e;

    // Violation reason; the numeric values are visible at the port.
    typedef enum logic [2:0] {
        VC_NONE     = 3'd0,
        VC_MRS_BUSY = 3'd1,
        VC_MRS_OPEN = 3'd2,
        VC_REF_OPEN = 3'd3,
        VC_ACT_OPEN = 3'd4,
        VC_RW_IDLE  = 3'd5,
        VC_WAP_LOCK = 3'd6,
        VC_RSVD     = 3'd7
    } vcode_e;

endpackage

// File: rtl/ddr_cmd_decode.sv
// Command decoder: maps CKE history and the strobe group to one operation.
// Assumes: cke_prev is the CKE value of the previous clock. With CKE low now,
// only the refresh encoding survives (self-refresh entry); all else is NOP.
module ddr_cmd_decode
    import ddr_chk_pkg::*;
(
    input  logic cke_prev,
    input  logic cke,
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output op_e  op
);

    // Combinational strobe decode with CKE qualification.
    always_comb begin
        op = OP_NOP;
        if (cke_prev && !cs_n) begin
            case ({ras_n, cas_n, we_n})
                3'b011:  op = OP_ACT;
                3'b101:  op = OP_RD;
                3'b100:  op = OP_WR;
                3'b010:  op = OP_PRE;
                3'b001:  op = OP_REF;
                3'b000:  op = OP_MRS;
                3'b110:  op = OP_BST;
                default: op = OP_NOP;
            endcase
        end
        if (!cke && op != OP_REF) begin
            op = OP_NOP;
        end
    end

endmodule

// File: rtl/ddr_mrs_gap.sv
// Recovery window after a mode-register write.
// busy is high for GAP clocks following the clock that carried the write.
// Assumes: a mode-register write inside the window restarts the window.
module ddr_mrs_gap
    import ddr_chk_pkg::*;
#(
    parameter int GAP = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  op_e  op,
    output logic busy
);

    localparam int GW = $clog2(GAP + 1);

    logic [GW-1:0] left_q;

    // Load on a mode-register write, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (op == OP_MRS) begin
            left_q <= GW'(GAP);
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign busy = (left_q != '0);

endmodule

// File: rtl/ddr_bank_track.sv
// Per-bank open/idle tracking plus the write auto-precharge lockout counter.
// Assumes: commands update state whether legal or not. A lockout that expires
// closes the written bank unless the same clock carries an activate to it.
module ddr_bank_track
    import ddr_chk_pkg::*;
#(
    parameter  int BA_W      = 2,
    parameter  int BURST_LEN = 4,
    localparam int NB        = 1 << BA_W,
    localparam int WAP_CYC   = BURST_LEN / 2,
    localparam int CNT_W     = $clog2(WAP_CYC + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  op_e             op,
    input  logic [BA_W-1:0] bank,
    input  logic            ap,
    output logic [NB-1:0]   bank_open,
    output logic [CNT_W-1:0] wap_left
);

    logic [NB-1:0]   open_q;
    logic [NB-1:0]   open_d;
    logic [CNT_W-1:0] left_q;
    logic [BA_W-1:0] wbank_q;
    logic            wap_end;

    assign wap_end = (left_q == CNT_W'(1));

    // Next open flag for every bank: commands win over the lockout expiry.
    for (genvar g = 0; g < NB; g++) begin : g_bank
        logic hit;
        assign hit = (bank == BA_W'(g));
        assign open_d[g] = (op == OP_ACT && hit)                ? 1'b1 :
                           (op == OP_PRE && (ap || hit))        ? 1'b0 :
                           (op == OP_RD && ap && hit)           ? 1'b0 :
                           (wap_end && wbank_q == BA_W'(g))     ? 1'b0 :
                                                                  open_q[g];
    end

    // Register the bank flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= '0;
        end else begin
            open_q <= open_d;
        end
    end

    // Lockout counter and the bank it belongs to.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q  <= '0;
            wbank_q <= '0;
        end else if (op == OP_WR && ap) begin
            left_q  <= CNT_W'(WAP_CYC);
            wbank_q <= bank;
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign bank_open = open_q;
    assign wap_left  = left_q;

endmodule

// File: rtl/ddr_cmd_checker.sv
// Top of the DDR command legality monitor.
// Decodes each clock's command, classifies it against bank state, the
// mode-register recovery window and the write auto-precharge lockout, and
// registers a one-cycle violation pulse with a reason code.
// Assumes: BURST_LEN is 2, 4 or 8; the monitor never drives the memory.
module ddr_cmd_checker
    import ddr_chk_pkg::*;
#(
    parameter  int BA_W      = 2,
    parameter  int BURST_LEN = 4,
    parameter  int MRS_GAP   = 2,
    localparam int NB        = 1 << BA_W,
    localparam int WAP_CYC   = BURST_LEN / 2,
    localparam int CNT_W     = $clog2(WAP_CYC + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cke,
    input  logic            cs_n,
    input  logic            ras_n,
    input  logic            cas_n,
    input  logic            we_n,
    input  logic [BA_W-1:0] ba,
    input  logic            addr_ap,
    output logic            viol,
    output logic [2:0]      viol_code
);

    logic            cke_prev;
    op_e             cmd_op;
    logic [NB-1:0]   bank_open;
    logic [CNT_W-1:0] wap_left;
    logic            mrs_busy;
    logic            wap_busy;
    logic            any_open;
    vcode_e          code_d;

    // Remember CKE from the previous clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cke_prev <= 1'b0;
        end else begin
            cke_prev <= cke;
        end
    end

    ddr_cmd_decode u_decode (
        .cke_prev (cke_prev),
        .cke      (cke),
        .cs_n     (cs_n),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .we_n     (we_n),
        .op       (cmd_op)
    );

    ddr_mrs_gap #(
        .GAP (MRS_GAP)
    ) u_gap (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (cmd_op),
        .busy  (mrs_busy)
    );

    ddr_bank_track #(
        .BA_W      (BA_W),
        .BURST_LEN (BURST_LEN)
    ) u_banks (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (cmd_op),
        .bank      (ba),
        .ap        (addr_ap),
        .bank_open (bank_open),
        .wap_left  (wap_left)
    );

    assign wap_busy = (wap_left != '0);
    assign any_open = |bank_open;

    // Classify the current command; recovery window has top priority.
    always_comb begin
        code_d = VC_NONE;
        if (mrs_busy && cmd_op != OP_NOP) begin
            code_d = VC_MRS_BUSY;
        end else begin
            case (cmd_op)
                OP_MRS: if (any_open)      code_d = VC_MRS_OPEN;
                OP_REF: if (any_open)      code_d = VC_REF_OPEN;
                OP_ACT: if (bank_open[ba]) code_d = VC_ACT_OPEN;
                OP_RD, OP_WR: begin
                    if (wap_busy)           code_d = VC_WAP_LOCK;
                    else if (!bank_open[ba]) code_d = VC_RW_IDLE;
                end
                default: code_d = VC_NONE;
            endcase
        end
    end

    // Register the reported pulse and reason.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            viol      <= 1'b0;
            viol_code <= 3'd0;
        end else begin
            viol      <= (code_d != VC_NONE);
            viol_code <= code_d;
        end
    end

endmodule

// File: rtl/ddr_cmd_checker_sva.sv
// Property checker for the DDR command legality monitor, bound to the top.
// Assumes: observes decoded command and state one clock before the reported code.
module ddr_cmd_checker_sva
    import ddr_chk_pkg::*;
#(
    parameter  int BA_W    = 2,
    parameter  int WAP_CYC = 2,
    parameter  int CNT_W   = 2,
    localparam int NB      = 1 << BA_W
) (
    input logic             clk,
    input logic             rst_n,
    input op_e              cmd_op,
    input logic [BA_W-1:0]  ba,
    input logic             addr_ap,
    input logic [NB-1:0]    bank_open,
    input logic [CNT_W-1:0] wap_left,
    input logic             mrs_busy,
    input logic             viol,
    input logic [2:0]       viol_code
);

    // R1: a no-operation never reports
    p_nop_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == OP_NOP) |=> !viol);

    // R3: all-bank precharge leaves every bank idle
    p_prea_closes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == OP_PRE && addr_ap) |=> (bank_open == '0));

    // R4: mode write with an open bank
    p_mrs_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mrs_busy && cmd_op == OP_MRS && bank_open != '0) |=> (viol_code == VC_MRS_OPEN));

    // R5: non-NOP inside the recovery window
    p_mrs_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mrs_busy && cmd_op != OP_NOP) |=> (viol && viol_code == VC_MRS_BUSY));

    // R6: refresh with an open bank
    p_ref_open_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!mrs_busy && cmd_op == OP_REF && bank_open != '0) |=> (viol_code == VC_REF_OPEN));

    // R8: activate on an open bank
    p_act_open_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!mrs_busy && cmd_op == OP_ACT && bank_open[ba]) |=> (viol_code == VC_ACT_OPEN));

    // R9: lockout loads to its full length and never exceeds it
    p_wap_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == OP_WR && addr_ap) |=> (wap_left == CNT_W'(WAP_CYC)));

    p_wap_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wap_left <= CNT_W'(WAP_CYC));

    // R9: access during the lockout
    p_wap_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!mrs_busy && wap_left != '0 && (cmd_op == OP_RD || cmd_op == OP_WR))
        |=> (viol_code == VC_WAP_LOCK));

    // R10: read with auto-precharge closes its bank
    p_rdap_close_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == OP_RD && addr_ap) |=> !bank_open[$past(ba)]);

    // R11: burst stop is silent outside the window
    p_bst_silent_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!mrs_busy && cmd_op == OP_BST) |=> !viol);

endmodule

bind ddr_cmd_checker ddr_cmd_checker_sva #(
    .BA_W    (BA_W),
    .WAP_CYC (WAP_CYC),
    .CNT_W   (CNT_W)
) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_op    (cmd_op),
    .ba        (ba),
    .addr_ap   (addr_ap),
    .bank_open (bank_open),
    .wap_left  (wap_left),
    .mrs_busy  (mrs_busy),
    .viol      (viol),
    .viol_code (viol_code)
);

// File: tb/ddr_cmd_checker_tb.sv
// Bench for the DDR command legality monitor: directed edge cases followed by
// seeded random command streams, all compared to a bench-side model.
module ddr_cmd_checker_tb;

    localparam int BURST_LEN = 4;
    localparam int WAP       = BURST_LEN / 2;
    localparam int GAP       = 2;

    // Operation numbers used only inside the bench.
    localparam int B_NOP = 0, B_ACT = 1, B_RD = 2, B_WR = 3,
                   B_PRE = 4, B_REF = 5, B_MRS = 6, B_BST = 7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cke = 1'b1;
    logic       cs_n = 1'b1;
    logic       ras_n = 1'b1;
    logic       cas_n = 1'b1;
    logic       we_n = 1'b1;
    logic [1:0] ba = 2'd0;
    logic       addr_ap = 1'b0;
    logic       viol;
    logic [2:0] viol_code;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // Bench model state
    bit [3:0] m_open = '0;
    int       m_gap = 0;
    int       m_left = 0;
    int       m_wbank = 0;
    bit       m_ckep = 1'b0;

    always #10 clk = ~clk;

    ddr_cmd_checker #(
        .BA_W      (2),
        .BURST_LEN (BURST_LEN),
        .MRS_GAP   (GAP)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cke       (cke),
        .cs_n      (cs_n),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .we_n      (we_n),
        .ba        (ba),
        .addr_ap   (addr_ap),
        .viol      (viol),
        .viol_code (viol_code)
    );

    // R1 decode from pins and CKE history
    function automatic int bdecode(bit ckep, bit ck, bit cs, bit r, bit c, bit w);
        int o = B_NOP;
        if (ckep && !cs) begin
            case ({r, c, w})
                3'b011:  o = B_ACT;
                3'b101:  o = B_RD;
                3'b100:  o = B_WR;
                3'b010:  o = B_PRE;
                3'b001:  o = B_REF;
                3'b000:  o = B_MRS;
                3'b110:  o = B_BST;
                default: o = B_NOP;
            endcase
        end
        if (!ck && o != B_REF) o = B_NOP;
        return o;
    endfunction

    // Expected code from the requirements, given model state before the edge
    function automatic int exp_code(int o, int b);
        if (m_gap > 0 && o != B_NOP) return 1;          // R5
        case (o)
            B_MRS: return (m_open != 0) ? 2 : 0;        // R4
            B_REF: return (m_open != 0) ? 3 : 0;        // R6
            B_ACT: return m_open[b] ? 4 : 0;            // R8
            B_RD, B_WR: begin
                if (m_left > 0) return 6;               // R9
                return m_open[b] ? 0 : 5;               // R7
            end
            default: return 0;                          // R11
        endcase
    endfunction

    function automatic string tag_of(int e);
        case (e)
            1: return "R5";
            2: return "R4";
            3: return "R6";
            4: return "R8";
            5: return "R7";
            6: return "R9";
            default: return "R12";
        endcase
    endfunction

    // Model state update, command accepted regardless of legality (R12)
    task automatic model_update(int o, int b, bit ap, bit ck);
        if (m_left > 0) begin
            if (m_left == 1) m_open[m_wbank] = 1'b0;
            m_left--;
        end
        case (o)
            B_ACT: m_open[b] = 1'b1;
            B_PRE: if (ap) m_open = '0; else m_open[b] = 1'b0;   // R3
            B_RD:  if (ap) m_open[b] = 1'b0;                     // R10
            B_WR:  if (ap) begin m_left = WAP; m_wbank = b; end  // R9
            default: ;
        endcase
        if (m_gap > 0) m_gap--;
        if (o == B_MRS) m_gap = GAP;
        m_ckep = ck;
    endtask

    // Drive pins at a falling edge, check one clock later at the next falling edge
    task automatic drive(bit cs, bit r, bit c, bit w, bit ck, bit [1:0] b, bit ap, string tag);
        int o;
        int e;
        cs_n = cs; ras_n = r; cas_n = c; we_n = w; cke = ck; ba = b; addr_ap = ap;
        o = bdecode(m_ckep, ck, cs, r, c, w);
        e = exp_code(o, int'(b));
        model_update(o, int'(b), ap, ck);
        @(negedge clk);
        checks++;
        if (viol !== (e != 0) || viol_code !== 3'(e)) begin
            errors++;
            $display("FAIL %s: viol=%0b code=%0d expected viol=%0b code=%0d",
                     tag, viol, viol_code, (e != 0), e);
        end
    endtask

    task automatic issue(int o, bit [1:0] b, bit ap, string tag);
        bit [3:0] p;
        case (o)
            B_ACT:   p = 4'b0011;
            B_RD:    p = 4'b0101;
            B_WR:    p = 4'b0100;
            B_PRE:   p = 4'b0010;
            B_REF:   p = 4'b0001;
            B_MRS:   p = 4'b0000;
            B_BST:   p = 4'b0110;
            default: p = 4'b0111;
        endcase
        drive(p[3], p[2], p[1], p[0], 1'b1, b, ap, tag);
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed_val;
        seed_val = $urandom(32'h5EED_0042);

        // R12 reset state
        repeat (3) @(negedge clk);
        checks++;
        if (viol !== 1'b0 || viol_code !== 3'd0) begin
            errors++;
            $display("FAIL R12 reset: viol=%0b code=%0d expected viol=0 code=0", viol, viol_code);
        end
        rst_n = 1'b1;

        // R1: idle cycles, deselect with garbage strobes, explicit NOP
        issue(B_NOP, 2'd0, 1'b0, "R1");
        issue(B_NOP, 2'd0, 1'b0, "R1");
        drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 2'd3, 1'b1, "R1");
        drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 2'd1, 1'b0, "R1");

        // R2 / R8: open every bank, then re-open one
        issue(B_ACT, 2'd0, 1'b0, "R2");
        issue(B_ACT, 2'd1, 1'b0, "R2");
        issue(B_ACT, 2'd2, 1'b0, "R2");
        issue(B_ACT, 2'd3, 1'b0, "R2");
        issue(B_ACT, 2'd2, 1'b0, "R8");

        // R3: single-bank precharge, then all-bank with BA ignored
        issue(B_PRE, 2'd1, 1'b0, "R3");
        issue(B_RD,  2'd1, 1'b0, "R3");
        issue(B_RD,  2'd0, 1'b0, "R3");
        issue(B_PRE, 2'd3, 1'b1, "R3");
        issue(B_RD,  2'd2, 1'b0, "R3");
        issue(B_ACT, 2'd0, 1'b0, "R3");

        // R4: mode write with bank 0 open; R5 window covers the next two clocks
        issue(B_MRS, 2'd0, 1'b0, "R4");
        issue(B_PRE, 2'd0, 1'b1, "R5");
        issue(B_NOP, 2'd0, 1'b0, "R5");
        issue(B_PRE, 2'd0, 1'b1, "R3");
        // R5: legal mode write, NOP, blocked command, first free clock
        issue(B_MRS, 2'd2, 1'b0, "R4");
        issue(B_NOP, 2'd0, 1'b0, "R5");
        issue(B_ACT, 2'd1, 1'b0, "R5");
        issue(B_ACT, 2'd1, 1'b0, "R5");
        // R11 inside the window is still flagged
        issue(B_PRE, 2'd0, 1'b1, "R3");
        issue(B_MRS, 2'd0, 1'b0, "R4");
        issue(B_BST, 2'd0, 1'b0, "R5");
        issue(B_NOP, 2'd0, 1'b0, "R5");

        // R6: refresh with open bank, then idle refresh, self-refresh entry
        issue(B_ACT, 2'd3, 1'b0, "R6");
        issue(B_REF, 2'd0, 1'b0, "R6");
        drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, "R6");
        drive(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0, 1'b0, "R1");
        drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 2'd3, 1'b0, "R1");
        issue(B_PRE, 2'd0, 1'b1, "R3");
        issue(B_REF, 2'd0, 1'b0, "R6");
        // R1: CKE low masks an activate
        drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'd1, 1'b0, "R1");
        issue(B_NOP, 2'd0, 1'b0, "R1");
        issue(B_RD,  2'd1, 1'b0, "R1");

        // R7: write to idle bank
        issue(B_WR, 2'd2, 1'b0, "R7");

        // R9: write with auto-precharge, lockout of WAP clocks, bank idle after
        issue(B_ACT, 2'd2, 1'b0, "R9");
        issue(B_WR,  2'd2, 1'b1, "R9");
        issue(B_RD,  2'd1, 1'b0, "R9");
        issue(B_NOP, 2'd0, 1'b0, "R9");
        issue(B_RD,  2'd2, 1'b0, "R9");
        issue(B_ACT, 2'd2, 1'b0, "R9");

        // R10: read without and with auto-precharge
        issue(B_RD, 2'd2, 1'b0, "R10");
        issue(B_RD, 2'd2, 1'b0, "R10");
        issue(B_RD, 2'd2, 1'b1, "R10");
        issue(B_RD, 2'd2, 1'b0, "R10");

        // R11: burst stop with banks idle and with a bank open
        issue(B_BST, 2'd0, 1'b0, "R11");
        issue(B_ACT, 2'd0, 1'b0, "R11");
        issue(B_BST, 2'd3, 1'b1, "R11");
        issue(B_PRE, 2'd0, 1'b1, "R11");

        // Random streams: tag follows the expected reason
        for (int i = 0; i < 4000; i++) begin
            int  sel;
            int  o;
            bit  ck;
            bit  cs;
            bit [1:0] b;
            bit  ap;
            int  e;
            bit [3:0] p;
            sel = int'($urandom_range(0, 15));
            ck  = ($urandom_range(0, 99) >= 3);
            cs  = ($urandom_range(0, 99) < 5);
            b   = 2'($urandom_range(0, 3));
            ap  = 1'($urandom_range(0, 1));
            case (sel)
                3, 4, 5: o = B_ACT;
                6, 7:    o = B_RD;
                8, 9:    o = B_WR;
                10, 11:  o = B_PRE;
                12:      o = B_REF;
                13:      o = B_MRS;
                14:      o = B_BST;
                default: o = B_NOP;
            endcase
            case (o)
                B_ACT:   p = 4'b0011;
                B_RD:    p = 4'b0101;
                B_WR:    p = 4'b0100;
                B_PRE:   p = 4'b0010;
                B_REF:   p = 4'b0001;
                B_MRS:   p = 4'b0000;
                B_BST:   p = 4'b0110;
                default: p = 4'b0111;
            endcase
            if (cs) p[3] = 1'b1;
            e = exp_code(bdecode(m_ckep, ck, p[3], p[2], p[1], p[0]), int'(b));
            drive(p[3], p[2], p[1], p[0], ck, b, ap, tag_of(e));
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule